// File: doc/BRIEF.md
# Memory-Mapped Vectored Interrupt Controller

This block collects up to 32 interrupt request lines from peripherals and drives a single interrupt output toward a processor. Each line has a sticky status bit that is set whenever the line is high. The bit stays set until software acknowledges it. A per-line enable mask selects which latched requests count as pending. A two-bit master enable must be fully on before the output can rise.

Software reaches the controller over a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe with combinational read data. Besides loading the mask as a whole word, software can turn single enable bits on or off by writing a one to a dedicated set or clear register, so no read-modify-write is needed. It clears latched requests by writing ones to an acknowledge register. A vector register gives the number of the source to service next.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master-enable registers read zero, the vector register reads 0xFFFFFFFF and `cpuIrq` is low.
- R2: A write to byte offset 0x10 sets each enable bit where the data has a one and leaves every other enable bit unchanged.
- R3: A write to byte offset 0x14 clears each enable bit where the data has a one and leaves every other enable bit unchanged.
- R4: A status bit (read at offset 0x00, bit n for line n) is set on any clock edge where its line is high. It stays set after the line falls, until a write to offset 0x0C with a one in that bit position clears it. Writing all ones clears every bit.
- R5: If a line is high on the same edge as an acknowledge of its bit, the status bit stays set.
- R6: Offset 0x08 reads the enable mask, and a write there loads the whole mask. Offset 0x04 reads the bitwise AND of status and enable.
- R7: Offset 0x1C holds the master enable in data bits [1:0]. `cpuIrq` is high exactly when both bits are one and at least one pending bit is set. The values 0x1 and 0x2 keep the output low.
- R8: Offset 0x18 reads the index of the lowest-numbered pending bit, zero-extended to 32 bits, or 0xFFFFFFFF when nothing is pending.
- R9: Writes to offsets 0x00, 0x04 and 0x18 change nothing. Reads of offsets 0x0C, 0x10 and 0x14 return zero.
- R10: `busRdData` shows the addressed register in the same cycle while `busRdEn` is high, and is zero while `busRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | 32 | Peripheral interrupt lines, active high, synchronous to clk |
| busAddr | input | 5 | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, combinational from address and strobe |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the interrupt lines are already synchronous to the clock and that each write is a single-cycle strobe to a word-aligned address. They also assume that a write and a read never share a cycle. The bench meets these assumptions by changing every input on the falling edge and running one access at a time through write and read tasks. It raises lines either as one-cycle pulses or as levels held across a chosen acknowledge edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Word index of each register; software decodes these offsets.
  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } regSel_e;

  // Strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic    wrEnable;
    logic    wrSetEn;
    logic    wrClrEn;
    logic    wrAck;
    logic    wrMaster;
    logic    rdActive;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           strb
);

  localparam int WORD_LSB = 2;
  localparam int SEL_W    = 3;

  logic    addrHit;
  regSel_e addrSel;

  always_comb begin
    addrHit = (busAddr[WORD_LSB-1:0] == '0) &&
              ((busAddr >> (WORD_LSB + SEL_W)) == '0);
    addrSel = regSel_e'(busAddr[WORD_LSB+SEL_W-1:WORD_LSB]);
    strb          = '0;
    strb.rdSel    = addrSel;
    strb.rdActive = busRdEn && addrHit;
    if (busWrEn && addrHit) begin
      case (addrSel)
        SEL_ENABLE: strb.wrEnable = 1'b1;
        SEL_SETEN:  strb.wrSetEn  = 1'b1;
        SEL_CLREN:  strb.wrClrEn  = 1'b1;
        SEL_ACK:    strb.wrAck    = 1'b1;
        SEL_MASTER: strb.wrMaster = 1'b1;
        default:    ; // read-only registers take no write
      endcase
    end
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrq
);

  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int MASTER_W = 2;

  logic [NUM_SRC-1:0]  statusQ, enableQ, enableNext, pendW, wrMask, ackMask;
  logic [MASTER_W-1:0] masterQ;
  logic [IDX_W-1:0]    vecIdx;
  logic                anyPend;

  assign wrMask  = wrData[NUM_SRC-1:0];
  assign ackMask = strb.wrAck ? wrMask : '0;

  // Sticky capture: a high line on the acknowledge edge wins.
  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~ackMask) | srcIrq;
  end

  always_comb begin
    enableNext = enableQ;
    if (strb.wrEnable) enableNext = wrMask;
    if (strb.wrSetEn)  enableNext = enableQ | wrMask;
    if (strb.wrClrEn)  enableNext = enableQ & ~wrMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      enableQ <= enableNext;
      if (strb.wrMaster) masterQ <= wrData[MASTER_W-1:0];
    end
  end

  assign pendW   = statusQ & enableQ;
  assign anyPend = |pendW;
  assign cpuIrq  = (&masterQ) && anyPend;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    vecIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendW[i]) vecIdx = IDX_W'(i);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdActive) begin
      case (strb.rdSel)
        SEL_STATUS: rdData = DATA_W'(statusQ);
        SEL_PEND:   rdData = DATA_W'(pendW);
        SEL_ENABLE: rdData = DATA_W'(enableQ);
        SEL_VECTOR: rdData = anyPend ? DATA_W'(vecIdx) : '1;
        SEL_MASTER: rdData = DATA_W'(masterQ);
        default:    rdData = '0;
      endcase
    end
  end

  AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetEn |=> ((enableQ & $past(enableQ)) == $past(enableQ))); // R2

  AST_CLR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClrEn |=> ((enableQ & ~$past(enableQ)) == '0)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrAck |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R4

  AST_LINE_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    (srcIrq != '0) |=> ((statusQ & $past(srcIrq)) == $past(srcIrq))); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (masterQ == 2'b11 && pendW != '0)); // R7

  AST_VECTOR_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> (pendW[vecIdx] &&
      ((pendW & ((NUM_SRC'(1) << vecIdx) - NUM_SRC'(1))) == '0))); // R8

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  output logic               cpuIrq
);

  strobe_t strb;

  irqv_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  irqv_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .srcIrq (srcIrq),
    .strb   (strb),
    .wrData (busWrData),
    .rdData (busRdData),
    .cpuIrq (cpuIrq)
  );

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  localparam logic [4:0] A_STATUS = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                         A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                         A_VEC = 5'h18, A_MASTER = 5'h1C;
  localparam int NVEC = 6;
  // Columns: line pulse, enable mask, expected pending, expected vector.
  localparam logic [127:0] VEC_TABLE [NVEC] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'd0},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'd31},
    {32'h0000_F000, 32'h0000_A000, 32'h0000_A000, 32'd13},
    {32'h0000_00FF, 32'hFFFF_FF00, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h8000_0010, 32'hFFFF_FFFF, 32'h8000_0010, 32'd4},
    {32'h0F00_0000, 32'h0C00_0000, 32'h0C00_0000, 32'd26}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIrq = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        cpuIrq;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] lines);
    @(negedge clk);
    srcIrq = lines;
    @(negedge clk);
    srcIrq = '0;
  endtask

  task automatic irqNow(output logic [31:0] d);
    @(negedge clk);
    #2 d = {31'd0, cpuIrq};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_STATUS, rv); chk("R1 status", rv, 32'h0);
    rd(A_EN, rv);     chk("R1 enable", rv, 32'h0);
    rd(A_MASTER, rv); chk("R1 master", rv, 32'h0);
    rd(A_VEC, rv);    chk("R1 vector", rv, 32'hFFFF_FFFF);
    irqNow(rv);       chk("R1 cpuIrq", rv, 32'h0);

    // Table walk: R6 pending, R8 vector, R7 output
    wr(A_MASTER, 32'h3);
    for (int k = 0; k < NVEC; k++) begin
      wr(A_ACK, 32'hFFFF_FFFF);
      wr(A_CLR, 32'hFFFF_FFFF);
      wr(A_SET, VEC_TABLE[k][95:64]);
      pulse(VEC_TABLE[k][127:96]);
      rd(A_PEND, rv); chk("R6 pending", rv, VEC_TABLE[k][63:32]);
      rd(A_VEC, rv);  chk("R8 vector", rv, VEC_TABLE[k][31:0]);
      irqNow(rv);     chk("R7 cpuIrq", rv, {31'd0, VEC_TABLE[k][63:32] != 0});
    end

    // R2 / R3 / R6 enable manipulation
    wr(A_EN, 32'h0000_00F0);
    rd(A_EN, rv); chk("R6 enable load", rv, 32'h0000_00F0);
    wr(A_SET, 32'h0000_0101);
    rd(A_EN, rv); chk("R2 set-enable", rv, 32'h0000_01F1);
    wr(A_CLR, 32'h0000_0030);
    rd(A_EN, rv); chk("R3 clear-enable", rv, 32'h0000_01C1);

    // R4 sticky, partial and full acknowledge
    wr(A_ACK, 32'hFFFF_FFFF);
    pulse(32'h0000_0006);
    rd(A_STATUS, rv); chk("R4 sticky", rv, 32'h0000_0006);
    wr(A_ACK, 32'h0000_0002);
    rd(A_STATUS, rv); chk("R4 partial ack", rv, 32'h0000_0004);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STATUS, rv); chk("R4 ack all", rv, 32'h0);

    // R5 line held high across the acknowledge edge
    @(negedge clk); srcIrq = 32'h0000_0008;
    wr(A_ACK, 32'h0000_0008);
    srcIrq = '0;
    rd(A_STATUS, rv); chk("R5 set wins", rv, 32'h0000_0008);

    // R7 partial master enable keeps output low
    wr(A_EN, 32'h0000_0008);
    wr(A_MASTER, 32'h1);
    irqNow(rv); chk("R7 master=1", rv, 32'h0);
    wr(A_MASTER, 32'h2);
    irqNow(rv); chk("R7 master=2", rv, 32'h0);
    wr(A_MASTER, 32'h3);
    irqNow(rv); chk("R7 master=3", rv, 32'h1);

    // R9 read-only writes ignored, write-only reads zero
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, rv); chk("R9 status write ignored", rv, 32'h0000_0008);
    wr(A_PEND, 32'h0);
    wr(A_VEC, 32'h0);
    rd(A_VEC, rv); chk("R9 vector write ignored", rv, 32'd3);
    rd(A_ACK, rv); chk("R9 ack reads zero", rv, 32'h0);
    rd(A_SET, rv); chk("R9 set reads zero", rv, 32'h0);
    rd(A_CLR, rv); chk("R9 clear reads zero", rv, 32'h0);

    // R10 no read strobe gives zero
    @(negedge clk); busAddr = A_EN; busRdEn = 1'b0;
    #2 chk("R10 idle read data", busRdData, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule